// File: doc/BRIEF.md
# Command Ring Read Engine

This block is the controller side of an outbound command queue. Software places 32-bit command verbs in a circular buffer of 256 entries in memory and then moves a write pointer forward. The engine compares that pointer with its own read pointer. While entries are pending and fetching is allowed, it reads the next entry through a simple memory read port and presents the verb to the downstream link logic over a valid/ready interface.

Four small registers control the engine: the write pointer, the read pointer with a reset bit, a size selector and a run bit. The read pointer is cleared with a two-step exchange: set the reset bit and wait until it reads back set, then write zero and wait until the pointer reads zero. A parameter makes the reset bit clear itself, so the second write is not needed. Clearing the run bit stops fetching. The bit reads back as set until the verb in flight has been accepted downstream. While the controller is powered down, both pointer registers read as all ones.

Back-pressure on the verb output follows the usual rules. While `vrb_valid` is high and `vrb_ready` is low, the verb is held unchanged. A verb is consumed only on a cycle where both signals are high, and the read pointer moves only on that cycle. Software must keep the write pointer from reaching the entry just before the read pointer, because that state means the ring is full. It must also apply the pointer reset only while the run bit reads clear.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, all four registers read zero, `vrb_valid` is low and `mem_req` is low.
- R2: Register select `reg_addr` uses these codes: 0 is the write pointer in bits 7:0, 1 is the read pointer in bits 7:0 with its reset bit in bit 15, 2 is the size code in bits 1:0, and 3 is the run bit in bit 0. Unused bits read zero and written values read back.
- R3: A fetch starts only when all of these hold: the run bit is set, the size code is 2'b10, the reset bit is clear, `low_power` is low and the read pointer differs from the write pointer. The fetch drives `mem_req` for one cycle with `mem_idx` equal to the read pointer plus one, modulo 256. `mem_rdata` is taken one cycle after the request, and no further request is made until the verb has been accepted.
- R4: Verbs leave in ring order, and the index wraps from 255 to 0.
- R5: The read pointer increases by one on each accepted handshake. Apart from register writes, it changes at no other time.
- R6: While `vrb_valid` is high and `vrb_ready` is low, `vrb_valid` stays high and `vrb_data` stays stable.
- R7: `vrb_codec` carries bits 31:28 of the presented verb.
- R8: Any size code other than 2'b10 blocks fetching.
- R9: With SELF_CLEAR=0, writing the read pointer with bit 15 set makes it read 0x8000 and blocks fetching. A later write with bit 15 clear makes it read exactly 0x0000, and fetching resumes at entry 1.
- R10: With SELF_CLEAR=1, writing bit 15 returns the pointer to zero and the register reads 0x0000 without a second write.
- R11: Clearing the run bit stops new fetches. The run bit reads 1 while a verb is in flight or held, and reads 0 once that verb is accepted.
- R12: While `low_power` is high, both pointer registers read 0xFFFF and no fetch starts. The stored values come back when it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_power | input | 1 | Controller powered down |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| mem_req | output | 1 | Ring memory read request |
| mem_idx | output | 8 | Ring entry index to read |
| mem_rdata | input | 32 | Entry data, one cycle after request |
| vrb_valid | output | 1 | Verb available downstream |
| vrb_ready | input | 1 | Downstream accepts verb |
| vrb_data | output | 32 | Verb |
| vrb_codec | output | 4 | Codec address field of the verb |

## Verification
The fetch path is driven with four kinds of input. Short pending runs with `vrb_ready` held high confirm ordering and pointer arithmetic. A run with `vrb_ready` held low separates holding the verb from moving the pointer. A long run across index 255 shows the modulo wrap. Runs with a wrong size code, the reset bit set, `low_power` high or the run bit cleared must produce no verbs, which shows that each gate blocks fetching on its own. A second instance built with the self-clearing option shows that the pointer returns to zero after a single write.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic [1:0] {
    REG_WP   = 2'd0,
    REG_RP   = 2'd1,
    REG_SIZE = 2'd2,
    REG_CTL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_WAIT = 2'd1,
    F_HOLD = 2'd2
  } fetch_st_e;

  localparam int RP_RST_BIT = 15;

  // Size code that selects a ring of 2**ptr_w entries
  function automatic logic [1:0] size_code(input int ptr_w);
    if (ptr_w == 8)      return 2'b10;
    else if (ptr_w == 4) return 2'b01;
    else                 return 2'b00;
  endfunction
endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int REG_W      = 16,
  parameter bit SELF_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_power,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             adv,
  input  logic             busy,
  output logic [PTR_W-1:0] wp,
  output logic [PTR_W-1:0] rp,
  output logic             run_req,
  output logic             rst_hold,
  output logic             size_ok,
  output logic             run_rb
);
  localparam logic [1:0] SIZE_SEL = size_code(PTR_W);

  logic [1:0] size_q;
  logic       hold_on_set;
  logic       wr_wp, wr_rp, wr_size, wr_ctl;
  logic       unused_hi;

  assign unused_hi = ^wdata[RP_RST_BIT-1:PTR_W];

  generate
    if (SELF_CLEAR) begin : g_self_clear
      assign hold_on_set = 1'b0;
    end else begin : g_two_step
      assign hold_on_set = 1'b1;
    end
  endgenerate

  assign wr_wp   = wr_en && (addr == REG_WP);
  assign wr_rp   = wr_en && (addr == REG_RP);
  assign wr_size = wr_en && (addr == REG_SIZE);
  assign wr_ctl  = wr_en && (addr == REG_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      size_q  <= '0;
      run_req <= 1'b0;
    end else begin
      if (wr_wp)   wp      <= wdata[PTR_W-1:0];
      if (wr_size) size_q  <= wdata[1:0];
      if (wr_ctl)  run_req <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp       <= '0;
      rst_hold <= 1'b0;
    end else if (wr_rp) begin
      rp       <= '0;
      rst_hold <= wdata[RP_RST_BIT] & hold_on_set;
    end else if (adv && !rst_hold) begin
      rp <= rp + PTR_W'(1);
    end
  end

  assign size_ok = (size_q == SIZE_SEL);
  assign run_rb  = run_req | busy;

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_WP: begin
        if (low_power) rdata = '1;
        else           rdata[PTR_W-1:0] = wp;
      end
      REG_RP: begin
        if (low_power) rdata = '1;
        else begin
          rdata[PTR_W-1:0]  = rp;
          rdata[RP_RST_BIT] = rst_hold;
        end
      end
      REG_SIZE: rdata[1:0] = size_q;
      default:  rdata[0]   = run_rb;
    endcase
  end
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int VERB_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PTR_W-1:0]  rp,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_idx,
  input  logic [VERB_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [VERB_W-1:0] out_data,
  input  logic              out_ready,
  output logic              adv,
  output logic              busy
);
  fetch_st_e st;

  assign mem_req   = (st == F_IDLE) && go;
  assign mem_idx   = rp + PTR_W'(1);
  assign out_valid = (st == F_HOLD);
  assign adv       = (st == F_HOLD) && out_ready;
  assign busy      = (st != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      out_data <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (go) st <= F_WAIT;
        F_WAIT: begin
          out_data <= mem_rdata;
          st       <= F_HOLD;
        end
        F_HOLD: if (out_ready) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int VERB_W     = 32,
  parameter int CADDR_W    = 4,
  parameter int REG_W      = 16,
  parameter bit SELF_CLEAR = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               low_power,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               mem_req,
  output logic [PTR_W-1:0]   mem_idx,
  input  logic [VERB_W-1:0]  mem_rdata,
  output logic               vrb_valid,
  input  logic               vrb_ready,
  output logic [VERB_W-1:0]  vrb_data,
  output logic [CADDR_W-1:0] vrb_codec
);
  logic [PTR_W-1:0] wp_q;
  logic [PTR_W-1:0] rp_q;
  logic             run_req, rst_hold, size_ok, run_rb;
  logic             adv, busy, go;

  cmd_ring_regs #(
    .PTR_W(PTR_W), .REG_W(REG_W), .SELF_CLEAR(SELF_CLEAR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .low_power(low_power),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .adv(adv), .busy(busy),
    .wp(wp_q), .rp(rp_q), .run_req(run_req), .rst_hold(rst_hold),
    .size_ok(size_ok), .run_rb(run_rb)
  );

  assign go = run_req && !rst_hold && size_ok && !low_power && (wp_q != rp_q);

  cmd_ring_fetch #(
    .PTR_W(PTR_W), .VERB_W(VERB_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go), .rp(rp_q),
    .mem_req(mem_req), .mem_idx(mem_idx), .mem_rdata(mem_rdata),
    .out_valid(vrb_valid), .out_data(vrb_data), .out_ready(vrb_ready),
    .adv(adv), .busy(busy)
  );

  assign vrb_codec = vrb_data[VERB_W-1 -: CADDR_W];
endmodule

// File: rtl/cmd_ring_chk.sv
module cmd_ring_chk #(
  parameter int PTR_W  = 8,
  parameter int VERB_W = 32,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              low_power,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              mem_req,
  input logic              vrb_valid,
  input logic              vrb_ready,
  input logic [VERB_W-1:0] vrb_data,
  input logic [PTR_W-1:0]  rp,
  input logic              run_rb,
  input logic              rst_hold
);
  assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_rp_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(vrb_valid && vrb_ready) && !(reg_wr_en && reg_addr == 2'd1)) |=> $stable(rp));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vrb_valid && !vrb_ready) |=> (vrb_valid && $stable(vrb_data)));

  assert_reset_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |-> !mem_req);

  assert_run_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vrb_valid |-> run_rb);

  assert_dead_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && (reg_addr == 2'd0 || reg_addr == 2'd1)) |-> (reg_rdata == '1));

  assert_dead_nofetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> !mem_req);
endmodule

bind cmd_ring_engine cmd_ring_chk #(
  .PTR_W(PTR_W), .VERB_W(VERB_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .low_power(low_power),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .mem_req(mem_req), .vrb_valid(vrb_valid), .vrb_ready(vrb_ready),
  .vrb_data(vrb_data), .rp(rp_q), .run_rb(run_rb), .rst_hold(rst_hold)
);

// File: tb/cmd_ring_engine_test.sv
`timescale 1ns/1ps
module cmd_ring_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        low_power;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        wr_a, wr_b;
  logic [15:0] rdata_a, rdata_b;
  logic        mreq_a, mreq_b;
  logic [7:0]  midx_a, midx_b;
  logic [31:0] mrd_a, mrd_b;
  logic        val_a, val_b, rdy_a, rdy_b;
  logic [31:0] dat_a, dat_b;
  logic [3:0]  cd_a, cd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] got [0:511];
  logic [3:0]  got_cd [0:511];
  int          got_n = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] verb_of(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b[3:0], 12'hA5C, 8'h00, b};
  endfunction

  cmd_ring_engine #(.SELF_CLEAR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .low_power(low_power),
    .reg_wr_en(wr_a), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
    .mem_req(mreq_a), .mem_idx(midx_a), .mem_rdata(mrd_a),
    .vrb_valid(val_a), .vrb_ready(rdy_a), .vrb_data(dat_a), .vrb_codec(cd_a)
  );

  cmd_ring_engine #(.SELF_CLEAR(1'b1)) uut_sc (
    .clk(clk), .rst_n(rst_n), .low_power(low_power),
    .reg_wr_en(wr_b), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
    .mem_req(mreq_b), .mem_idx(midx_b), .mem_rdata(mrd_b),
    .vrb_valid(val_b), .vrb_ready(rdy_b), .vrb_data(dat_b), .vrb_codec(cd_b)
  );

  always @(posedge clk) begin
    if (mreq_a) mrd_a <= verb_of(int'(midx_a));
    if (mreq_b) mrd_b <= verb_of(int'(midx_b));
    if (val_a && rdy_a) begin
      got[got_n]    <= dat_a;
      got_cd[got_n] <= cd_a;
      got_n         <= got_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input bit sel_b, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d;
    if (sel_b) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd_reg(input bit sel_b, input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = sel_b ? rdata_b : rdata_a;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_seq(input string req, input int start, input int first, input int cnt);
    chk(req, got_n - start, cnt);
    for (int k = 0; k < cnt; k++) chk(req, got[start + k], verb_of((first + k) % 256));
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd_reg(0, a[1:0], v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 valid reset", val_a, 0);
    chk("R1 mem_req reset", mreq_a, 0);
  endtask

  task automatic t_size_gate;
    logic [15:0] v;
    int s = got_n;
    wr_reg(0, 2'd2, 16'h0001);
    wr_reg(0, 2'd3, 16'h0001);
    wr_reg(0, 2'd0, 16'h0003);
    wait_n(20);
    chk("R8 no verbs with wrong size", got_n - s, 0);
    rd_reg(0, 2'd1, v); chk("R8 rp unchanged", v, 0);
    rd_reg(0, 2'd2, v); chk("R2 size readback", v, 16'h0001);
    rd_reg(0, 2'd0, v); chk("R2 wp readback", v, 16'h0003);
    rd_reg(0, 2'd3, v); chk("R2 run readback", v, 16'h0001);
  endtask

  task automatic t_basic;
    logic [15:0] v;
    int s = got_n;
    logic [31:0] e;
    wr_reg(0, 2'd2, 16'h0002);
    wait_n(20);
    expect_seq("R3 R4 first burst", s, 1, 3);
    rd_reg(0, 2'd1, v); chk("R5 rp after burst", v, 3);
    for (int k = 0; k < 3; k++) begin
      e = verb_of(1 + k);
      chk("R7 codec field", got_cd[s + k], e[31:28]);
    end
    s = got_n;
    wr_reg(0, 2'd0, 16'h0005);
    wait_n(20);
    expect_seq("R4 second burst", s, 4, 2);
    rd_reg(0, 2'd1, v); chk("R5 rp after second burst", v, 5);
  endtask

  task automatic t_backpressure;
    logic [15:0] v;
    int s;
    rdy_a = 1'b0;
    wr_reg(0, 2'd0, 16'h0006);
    wait_n(10);
    chk("R6 valid held", val_a, 1);
    chk("R6 data held", dat_a, verb_of(6));
    rd_reg(0, 2'd1, v); chk("R5 rp waits for accept", v, 5);
    wait_n(5);
    chk("R6 data still stable", dat_a, verb_of(6));
    chk("R3 no extra read while held", mreq_a, 0);
    s = got_n;
    rdy_a = 1'b1;
    wait_n(5);
    expect_seq("R6 released verb", s, 6, 1);
    rd_reg(0, 2'd1, v); chk("R5 rp after release", v, 6);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    int s = got_n;
    wr_reg(0, 2'd0, 16'h00FF);
    wait_n(800);
    wr_reg(0, 2'd0, 16'h0002);
    wait_n(30);
    expect_seq("R4 wrap order", s, 7, 252);
    rd_reg(0, 2'd1, v); chk("R4 rp after wrap", v, 2);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    int s;
    rdy_a = 1'b0;
    wr_reg(0, 2'd0, 16'h0004);
    wait_n(10);
    wr_reg(0, 2'd3, 16'h0000);
    rd_reg(0, 2'd3, v); chk("R11 run reads set while held", v, 1);
    chk("R11 verb still offered", val_a, 1);
    s = got_n;
    rdy_a = 1'b1;
    wait_n(3);
    rd_reg(0, 2'd3, v); chk("R11 run reads clear after accept", v, 0);
    wait_n(10);
    expect_seq("R11 only in-flight verb", s, 3, 1);
    rd_reg(0, 2'd1, v); chk("R11 no fetch after stop", v, 3);
  endtask

  task automatic t_rp_reset;
    logic [15:0] v;
    int s = got_n;
    wr_reg(0, 2'd1, 16'h8000);
    rd_reg(0, 2'd1, v); chk("R9 reset bit reads set", v, 16'h8000);
    wr_reg(0, 2'd3, 16'h0001);
    wait_n(10);
    chk("R9 no fetch while reset bit set", got_n - s, 0);
    rd_reg(0, 2'd1, v); chk("R9 bit held", v, 16'h8000);
    wr_reg(0, 2'd1, 16'h0000);
    rd_reg(0, 2'd1, v); chk("R9 pointer reads zero", v, 16'h0000);
    wait_n(20);
    expect_seq("R9 resume from entry 1", s, 1, 4);
  endtask

  task automatic t_low_power;
    logic [15:0] v;
    int s = got_n;
    low_power = 1'b1;
    rd_reg(0, 2'd0, v); chk("R12 wp reads all ones", v, 16'hFFFF);
    rd_reg(0, 2'd1, v); chk("R12 rp reads all ones", v, 16'hFFFF);
    rd_reg(0, 2'd2, v); chk("R12 size unaffected", v, 16'h0002);
    wr_reg(0, 2'd0, 16'h0006);
    wait_n(10);
    chk("R12 no fetch in low power", got_n - s, 0);
    low_power = 1'b0;
    rd_reg(0, 2'd0, v); chk("R12 wp restored", v, 6);
    wait_n(20);
    expect_seq("R12 fetch resumes", s, 5, 2);
  endtask

  task automatic t_self_clear;
    logic [15:0] v;
    wr_reg(1, 2'd2, 16'h0002);
    wr_reg(1, 2'd0, 16'h0003);
    wr_reg(1, 2'd3, 16'h0001);
    wait_n(20);
    rd_reg(1, 2'd1, v); chk("R10 rp before reset", v, 3);
    wr_reg(1, 2'd3, 16'h0000);
    wait_n(3);
    wr_reg(1, 2'd1, 16'h8000);
    rd_reg(1, 2'd1, v); chk("R10 self-cleared pointer", v, 16'h0000);
    wr_reg(1, 2'd3, 16'h0001);
    wait_n(20);
    rd_reg(1, 2'd1, v); chk("R10 refetch after self clear", v, 3);
  endtask

  initial begin
    rst_n = 1'b0; low_power = 1'b0; reg_addr = '0; reg_wdata = '0;
    wr_a = 1'b0; wr_b = 1'b0; rdy_a = 1'b1; rdy_b = 1'b1;
    mrd_a = '0; mrd_b = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_size_gate();
    t_basic();
    t_backpressure();
    t_wrap();
    t_stop();
    t_rp_reset();
    t_low_power();
    t_self_clear();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule